// File: doc/BRIEF.md
# Two-Port Semaphore Flag Unit

This block holds a small bank of binary semaphore flags that two independent agents, a left port and a right port, use to claim and release shared resources. Each port selects a flag with an address, writes a single request bit into it, and reads back whether it holds that flag. Flags are active low. A side that writes 0 asks for the token. A side that writes 1 gives up its own claim. The unit lets at most one side own a flag at a time. A request from the side that lost stays pending, and it turns into ownership as soon as the owner releases the flag.

Software uses a set-then-test sequence. It writes 0 to a flag, then reads the flag back. If the read returns all zeros, the claim succeeded. If it returns all ones, the other side owns the flag. A read result is captured when the port's read enable becomes active and is then held steady until that enable drops. A flag change made by the other side therefore cannot alter a read that is in progress. All ports are synchronous to one clock.

Top module: `sema_top`

## Requirements
- R1: After reset every flag is free and each port's read result is 8'hFF. Reading any flag from either side returns 8'hFF.
- R2: A write (select=1, write strobe=1, write bit=0) to a free flag gives that side ownership. That side then reads 8'h00 and the other side reads 8'hFF.
- R3: The 3-bit address picks one of eight flags, and a write to one flag leaves every other flag unchanged.
- R4: A 0 written by the side that does not own a flag does not change ownership and is held pending. When the owner then writes 1, ownership passes directly to the pending side.
- R5: When the owner writes 1 and no request is pending, the flag becomes free and both sides read 8'hFF.
- R6: A write of 1 from a side that neither owns a flag nor has a request pending on it has no effect.
- R7: A pending request is withdrawn when its side writes 1. A later release by the owner then leaves the flag free.
- R8: If both sides write 0 to the same free flag in the same cycle, the left side gets ownership and the right request stays pending.
- R9: A read returns the flag status on all 8 data bits: 8'h00 when the reading side owns the flag, and 8'hFF otherwise.
- R10: A read is active when select=1, output enable=1 and write strobe=0. The result is captured at the first clock edge of an active read and appears one cycle later. It does not change again until the read goes inactive and then becomes active once more.
- R11: When the two sides request a free flag in different cycles, the earlier request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lSel | input | 1 | Left port select |
| lWr | input | 1 | Left write strobe |
| lOe | input | 1 | Left read/output enable |
| lAddr | input | 3 | Left flag address |
| lWrBit | input | 1 | Left request bit (0 requests, 1 releases) |
| lRdData | output | 8 | Left captured flag status, replicated |
| rSel | input | 1 | Right port select |
| rWr | input | 1 | Right write strobe |
| rOe | input | 1 | Right read/output enable |
| rAddr | input | 3 | Right flag address |
| rWrBit | input | 1 | Right request bit (0 requests, 1 releases) |
| rRdData | output | 8 | Right captured flag status, replicated |

## Verification
A wrong owner or request latch is seen only through a later read on one of the ports. It shows up on the second clock edge after the write that disturbed it: one edge for the write, one for the capture. A lost pending request is the hardest case to see. It stays invisible until the owner releases the flag, and only the next read then shows a free flag where a handover was due. For this reason each ownership scenario reads both sides after every step, and it always ends with a release. A fault in the capture edge detector shows up as a held read that changes in the middle of an access, or as a re-read that does not refresh.

// File: rtl/sema_pkg.sv
package sema_pkg;
  parameter int FLAG_CNT = 8;
  localparam int FLAG_AW = $clog2(FLAG_CNT);

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // strobes one port's control hands to the datapath each cycle
  typedef struct packed {
    logic [FLAG_CNT-1:0] wrEn;
    logic                wrVal;
    logic                capture;
    logic [FLAG_AW-1:0]  rdAddr;
  } portStrobe_t;
endpackage

// File: rtl/sema_port_ctrl.sv
module sema_port_ctrl
  import sema_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sel,
  input  logic               wr,
  input  logic               oe,
  input  logic [FLAG_AW-1:0] addr,
  input  logic               wrBit,
  output portStrobe_t        stb
);
  logic rdEn;
  logic rdEnQ;
  logic wrReq;

  assign wrReq = sel && wr;
  assign rdEn  = sel && oe && !wr;

  always_ff @(posedge clk) begin
    if (!rstN) rdEnQ <= 1'b0;
    else       rdEnQ <= rdEn;
  end

  always_comb begin
    stb         = '0;
    stb.wrVal   = wrBit;
    stb.rdAddr  = addr;
    stb.capture = rdEn && !rdEnQ;
    for (int i = 0; i < FLAG_CNT; i++) begin
      stb.wrEn[i] = wrReq && (addr == FLAG_AW'(i));
    end
  end
endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic lWrEn,
  input  logic lWrVal,
  input  logic rWrEn,
  input  logic rWrVal,
  output logic lOwn,
  output logic rOwn
);
  logic   lReq, rReq;       // active low request latches
  logic   lReqNext, rReqNext;
  owner_e owner, ownerNext;

  always_comb begin
    lReqNext  = lWrEn ? lWrVal : lReq;
    rReqNext  = rWrEn ? rWrVal : rReq;
    ownerNext = owner;
    unique case (owner)
      OWN_LEFT: begin
        if (lReqNext) ownerNext = rReqNext ? OWN_NONE : OWN_RIGHT;
      end
      OWN_RIGHT: begin
        if (rReqNext) ownerNext = lReqNext ? OWN_NONE : OWN_LEFT;
      end
      default: begin
        if (!lReqNext)      ownerNext = OWN_LEFT;
        else if (!rReqNext) ownerNext = OWN_RIGHT;
        else                ownerNext = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lReq  <= 1'b1;
      rReq  <= 1'b1;
      owner <= OWN_NONE;
    end else begin
      lReq  <= lReqNext;
      rReq  <= rReqNext;
      owner <= ownerNext;
    end
  end

  assign lOwn = (owner == OWN_LEFT);
  assign rOwn = (owner == OWN_RIGHT);
endmodule

// File: rtl/sema_flags.sv
module sema_flags
  import sema_pkg::*;
#(
  parameter int RD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobe_t         lStb,
  input  portStrobe_t         rStb,
  output logic [RD_W-1:0]     lRdData,
  output logic [RD_W-1:0]     rRdData,
  output logic [FLAG_CNT-1:0] lOwnVec,
  output logic [FLAG_CNT-1:0] rOwnVec
);
  for (genvar g = 0; g < FLAG_CNT; g++) begin : gFlag
    sema_cell cell_i (
      .clk   (clk),
      .rstN  (rstN),
      .lWrEn (lStb.wrEn[g]),
      .lWrVal(lStb.wrVal),
      .rWrEn (rStb.wrEn[g]),
      .rWrVal(rStb.wrVal),
      .lOwn  (lOwnVec[g]),
      .rOwn  (rOwnVec[g])
    );
  end

  logic lStatus, rStatus;
  assign lStatus = ~lOwnVec[lStb.rdAddr];
  assign rStatus = ~rOwnVec[rStb.rdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lRdData <= '1;
      rRdData <= '1;
    end else begin
      if (lStb.capture) lRdData <= {RD_W{lStatus}};
      if (rStb.capture) rRdData <= {RD_W{rStatus}};
    end
  end
endmodule

// File: rtl/sema_top.sv
module sema_top
  import sema_pkg::*;
#(
  parameter int RD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lSel,
  input  logic               lWr,
  input  logic               lOe,
  input  logic [FLAG_AW-1:0] lAddr,
  input  logic               lWrBit,
  output logic [RD_W-1:0]    lRdData,
  input  logic               rSel,
  input  logic               rWr,
  input  logic               rOe,
  input  logic [FLAG_AW-1:0] rAddr,
  input  logic               rWrBit,
  output logic [RD_W-1:0]    rRdData
);
  portStrobe_t lStb, rStb;
  logic [FLAG_CNT-1:0] lOwnVec, rOwnVec;

  sema_port_ctrl lCtrl_i (
    .clk(clk), .rstN(rstN), .sel(lSel), .wr(lWr), .oe(lOe),
    .addr(lAddr), .wrBit(lWrBit), .stb(lStb)
  );

  sema_port_ctrl rCtrl_i (
    .clk(clk), .rstN(rstN), .sel(rSel), .wr(rWr), .oe(rOe),
    .addr(rAddr), .wrBit(rWrBit), .stb(rStb)
  );

  sema_flags #(.RD_W(RD_W)) flags_i (
    .clk(clk), .rstN(rstN), .lStb(lStb), .rStb(rStb),
    .lRdData(lRdData), .rRdData(rRdData),
    .lOwnVec(lOwnVec), .rOwnVec(rOwnVec)
  );
endmodule

// File: rtl/sema_checker.sv
module sema_checker
  import sema_pkg::*;
#(
  parameter int RD_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                lSel,
  input logic                lWr,
  input logic                lOe,
  input logic [FLAG_AW-1:0]  lAddr,
  input logic                lWrBit,
  input logic [RD_W-1:0]     lRdData,
  input logic                rSel,
  input logic                rWr,
  input logic                rAddr_unused,
  input logic [FLAG_AW-1:0]  rAddr,
  input logic                rWrBit,
  input logic [RD_W-1:0]     rRdData,
  input logic [FLAG_CNT-1:0] lOwnVec,
  input logic [FLAG_CNT-1:0] rOwnVec
);
  logic lRead, lWrite, rWrite;
  assign lRead  = lSel && lOe && !lWr;
  assign lWrite = lSel && lWr;
  assign rWrite = rSel && rWr;

  AST_READ_REPLICATED: assert property (@(posedge clk) disable iff (!rstN)
    (lRdData == '0 || lRdData == '1) && (rRdData == '0 || rRdData == '1)); // R9

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (lRead && $past(lRead)) |=> $stable(lRdData)); // R10

  AST_NO_STEAL: assert property (@(posedge clk) disable iff (!rstN)
    (lOwnVec[rAddr] && rWrite && !(lWrite && lAddr == rAddr)) |=> lOwnVec[$past(rAddr)]); // R4

  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (lWrite && rWrite && lAddr == rAddr && !lWrBit && !rWrBit
     && !lOwnVec[lAddr] && !rOwnVec[lAddr]) |=> lOwnVec[$past(lAddr)]); // R8

  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (lOwnVec[lAddr] && lWrite && lWrBit) |=> !lOwnVec[$past(lAddr)]); // R5
endmodule

bind sema_top sema_checker #(.RD_W(RD_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .lSel(lSel), .lWr(lWr), .lOe(lOe), .lAddr(lAddr), .lWrBit(lWrBit), .lRdData(lRdData),
  .rSel(rSel), .rWr(rWr), .rAddr_unused(rOe), .rAddr(rAddr), .rWrBit(rWrBit), .rRdData(rRdData),
  .lOwnVec(lOwnVec), .rOwnVec(rOwnVec)
);

// File: tb/sema_top_tb_top.sv
module sema_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lSel = 0, lWr = 0, lOe = 0, lWrBit = 1;
  logic rSel = 0, rWr = 0, rOe = 0, rWrBit = 1;
  logic [2:0] lAddr = '0, rAddr = '0;
  logic [7:0] lRdData, rRdData;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sema_top dut_i (
    .clk(clk), .rstN(rstN),
    .lSel(lSel), .lWr(lWr), .lOe(lOe), .lAddr(lAddr), .lWrBit(lWrBit), .lRdData(lRdData),
    .rSel(rSel), .rWr(rWr), .rOe(rOe), .rAddr(rAddr), .rWrBit(rWrBit), .rRdData(rRdData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lWrite(input logic [2:0] a, input logic b);
    @(negedge clk); lSel = 1; lWr = 1; lAddr = a; lWrBit = b;
    @(negedge clk); lSel = 0; lWr = 0;
  endtask

  task automatic rWrite(input logic [2:0] a, input logic b);
    @(negedge clk); rSel = 1; rWr = 1; rAddr = a; rWrBit = b;
    @(negedge clk); rSel = 0; rWr = 0;
  endtask

  task automatic lRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); lSel = 1; lOe = 1; lAddr = a;
    @(negedge clk); d = lRdData; lSel = 0; lOe = 0;
  endtask

  task automatic rRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rSel = 1; rOe = 1; rAddr = a;
    @(negedge clk); d = rRdData; rSel = 0; rOe = 0;
  endtask

  task automatic expectBoth(input string req, input logic [2:0] a,
                            input logic [7:0] le, input logic [7:0] re);
    logic [7:0] d;
    lRead(a, d); check({req, " left"}, d, le);
    rRead(a, d); check({req, " right"}, d, re);
  endtask

  task automatic t_reset;
    check("R1 left out", lRdData, 8'hFF);
    check("R1 right out", rRdData, 8'hFF);
    expectBoth("R1 flag0", 3'd0, 8'hFF, 8'hFF);
    expectBoth("R1 flag7", 3'd7, 8'hFF, 8'hFF);
  endtask

  task automatic t_claim;
    lWrite(3'd2, 1'b0);
    expectBoth("R2 R9 claim", 3'd2, 8'h00, 8'hFF);
    expectBoth("R3 neighbour", 3'd3, 8'hFF, 8'hFF);
    expectBoth("R3 other", 3'd1, 8'hFF, 8'hFF);
  endtask

  task automatic t_pending;
    rWrite(3'd2, 1'b0);
    expectBoth("R4 pending kept", 3'd2, 8'h00, 8'hFF);
    lWrite(3'd2, 1'b1);
    expectBoth("R4 handover", 3'd2, 8'hFF, 8'h00);
    rWrite(3'd2, 1'b1);
    expectBoth("R5 free", 3'd2, 8'hFF, 8'hFF);
  endtask

  task automatic t_stray;
    rWrite(3'd5, 1'b1);
    expectBoth("R6 free stray", 3'd5, 8'hFF, 8'hFF);
    lWrite(3'd5, 1'b0);
    rWrite(3'd5, 1'b1);
    expectBoth("R6 owned stray", 3'd5, 8'h00, 8'hFF);
    lWrite(3'd5, 1'b1);
    expectBoth("R6 R5 release", 3'd5, 8'hFF, 8'hFF);
  endtask

  task automatic t_cancel;
    lWrite(3'd1, 1'b0);
    rWrite(3'd1, 1'b0);
    rWrite(3'd1, 1'b1);
    expectBoth("R7 still left", 3'd1, 8'h00, 8'hFF);
    lWrite(3'd1, 1'b1);
    expectBoth("R7 free", 3'd1, 8'hFF, 8'hFF);
  endtask

  task automatic t_tie;
    @(negedge clk);
    lSel = 1; lWr = 1; lAddr = 3'd4; lWrBit = 0;
    rSel = 1; rWr = 1; rAddr = 3'd4; rWrBit = 0;
    @(negedge clk);
    lSel = 0; lWr = 0; rSel = 0; rWr = 0;
    expectBoth("R8 left wins", 3'd4, 8'h00, 8'hFF);
    lWrite(3'd4, 1'b1);
    expectBoth("R8 right pending", 3'd4, 8'hFF, 8'h00);
    rWrite(3'd4, 1'b1);
    expectBoth("R8 free", 3'd4, 8'hFF, 8'hFF);
  endtask

  task automatic t_order;
    @(negedge clk); rSel = 1; rWr = 1; rAddr = 3'd6; rWrBit = 0;
    @(negedge clk); rSel = 0; rWr = 0;
    lSel = 1; lWr = 1; lAddr = 3'd6; lWrBit = 0;
    @(negedge clk); lSel = 0; lWr = 0;
    expectBoth("R11 right first", 3'd6, 8'hFF, 8'h00);
    rWrite(3'd6, 1'b1);
    expectBoth("R11 left next", 3'd6, 8'h00, 8'hFF);
    lWrite(3'd6, 1'b1);
  endtask

  task automatic t_hold;
    lWrite(3'd0, 1'b0);
    rWrite(3'd0, 1'b0);
    @(negedge clk); rSel = 1; rOe = 1; rAddr = 3'd0;
    @(negedge clk); check("R10 capture", rRdData, 8'hFF);
    lWrite(3'd0, 1'b1);
    @(negedge clk); check("R10 held", rRdData, 8'hFF);
    rOe = 0;
    @(negedge clk); rOe = 1;
    @(negedge clk); check("R10 refreshed", rRdData, 8'h00);
    rSel = 0; rOe = 0;
    rWrite(3'd0, 1'b1);
    expectBoth("R10 cleanup", 3'd0, 8'hFF, 8'hFF);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_claim();
    t_pending();
    t_stray();
    t_cancel();
    t_tie();
    t_order();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule